// File: doc/BRIEF.md
# DMA Page Translation Unit

This block turns logical DMA addresses into physical addresses through a per-page table. Each table slot holds the physical frame of one 4096-byte page. The logical page number (address bits 31:12) selects a slot. The physical address is that slot's frame with its low 12 bits replaced by the page offset of the logical address.

Software programs two 32-bit settings: a table base address and a table limit in bytes. Either write clears every mapping. It then starts a fill sequencer, which reads the table from system memory one 8-byte slot at a time and keeps the first 32-bit word of each slot as the frame. Software can also write a slot directly through the table-write port. A write at an 8-byte-aligned offset changes that page's frame and maps the page at once.

Fill reads use a request channel with valid/ready. The unit raises `mem_req_valid` with `mem_req_addr` and holds both stable until the cycle in which `mem_req_ready` is high. Only one read is outstanding at a time. The response channel has no back-pressure: memory returns exactly one `mem_rsp_valid` pulse per accepted request, in order, at least one cycle after acceptance, and the unit always takes it. Lookups are plain strobes: `lk_valid` in one cycle gives `res_valid` with the result in the next.

Top module: `pxu_top`

## Requirements
- R1: After reset, `busy`, `err`, `mem_req_valid` and `res_valid` are 0, and every lookup misses.
- R2: A lookup with `lk_valid` high gives `res_valid` high in the next cycle. On a hit, `res_paddr` is `{frame[31:12], lk_addr[11:0]}`, where frame is the stored first word of slot `lk_addr[31:12]`. On a miss, `res_paddr` is 0.
- R3: The fill reads slot i from `(base & 32'h7FFF_FFFF) + 8*i`, with i ascending from 0. While `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` are held.
- R4: The fill loads `min(limit, 4096) / 8` slots, rounded down. Pages at or above that count miss unless they are written directly.
- R5: With a limit of 0, no reads are issued and every lookup misses, even pages written directly.
- R6: A setting write (`cfg_sel`=0 for base, 1 for limit) unmaps every page and restarts the fill from slot 0, also when a fill is already running. A read that was already in flight is discarded.
- R7: A table write at byte offset `tw_addr` with `tw_addr[2:0]`=0 and slot index `tw_addr[15:3]` below 512 stores `tw_data` as that slot's frame and maps the page. A lookup issued in any later cycle sees the change.
- R8: A table write with `tw_addr[2:0]` not 0 changes no mapping and no frame.
- R9: An aligned table write whose slot index is 512 or more maps nothing and sets `err`, which then stays 1 until reset.
- R10: While a fill runs, `busy` is 1 and every lookup misses. When idle, `mem_req_valid` is 0.
- R11: A lookup whose page number `lk_addr[31:12]` is 512 or more misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 1 | 0: table base, 1: table limit |
| cfg_wdata | input | 32 | Setting write data |
| tw_we | input | 1 | Table write strobe |
| tw_addr | input | 16 | Byte offset into the table |
| tw_data | input | 32 | Table write data |
| mem_req_valid | output | 1 | Fill read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Fill read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data (slot frame word) |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 32 | Logical address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Translation found |
| res_paddr | output | 32 | Physical address |
| busy | output | 1 | Fill in progress |
| err | output | 1 | Sticky out-of-range table write flag |

## Verification
Lookup results are registered, so the bench raises `lk_valid` on a falling edge, drops it on the next falling edge, and samples `res_*` at that point, one rising edge later. A table write has its effect at the rising edge that captures it, so the bench issues the lookup for that page on the next falling edge. `err` is sampled on the falling edge after the write. After a setting write, `busy` rises at the next rising edge. The bench polls `busy` on falling edges until the fill ends, then compares the number of read handshakes and the last read address with the values computed from the base and the limit.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int PXU_AW          = 32;
  localparam int PXU_PAGE_BITS   = 12;
  localparam int PXU_MAX_PAGES   = 512;
  localparam int PXU_ENTRY_BYTES = 8;
  localparam int PXU_TW_AW       = 16;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fill_state_e;
endpackage

// File: rtl/pxu_fill.sv
module pxu_fill
  import pxu_pkg::*;
#(
  parameter int AW     = 32,
  parameter int IDX_W  = 9,
  parameter int CNT_W  = 10,
  parameter int ENT_SH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    start_base,
  input  logic [CNT_W-1:0] start_cnt,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [AW-1:0]    mem_rsp_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [AW-1:0]    wr_data,
  output logic             busy
);
  fill_state_e      state_q;
  logic [AW-1:0]    base_q, addr_q;
  logic [CNT_W-1:0] cnt_q, idx_q, idx_nx;
  logic             skip_q;

  assign idx_nx = idx_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      base_q  <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      skip_q  <= 1'b0;
    end else if (start) begin
      base_q <= start_base;
      cnt_q  <= start_cnt;
      idx_q  <= '0;
      if (state_q == FS_IDLE || (state_q == FS_WAIT && mem_rsp_valid)) begin
        skip_q <= 1'b0;
        if (start_cnt != '0) begin
          state_q <= FS_REQ;
          addr_q  <= start_base;
        end else begin
          state_q <= FS_IDLE;
        end
      end else begin
        // a read is pending or in flight: let it finish and drop its data
        skip_q <= 1'b1;
        if (state_q == FS_REQ && mem_req_ready) state_q <= FS_WAIT;
      end
    end else begin
      case (state_q)
        FS_REQ: if (mem_req_ready) state_q <= FS_WAIT;
        FS_WAIT: if (mem_rsp_valid) begin
          if (skip_q) begin
            skip_q <= 1'b0;
            if (cnt_q != '0) begin
              state_q <= FS_REQ;
              addr_q  <= base_q;
            end else begin
              state_q <= FS_IDLE;
            end
          end else begin
            idx_q <= idx_nx;
            if (idx_nx == cnt_q) begin
              state_q <= FS_IDLE;
            end else begin
              state_q <= FS_REQ;
              addr_q  <= base_q + (AW'(idx_nx) << ENT_SH);
            end
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state_q == FS_REQ);
  assign mem_req_addr  = addr_q;
  assign wr_en   = (state_q == FS_WAIT) && mem_rsp_valid && !skip_q && !start;
  assign wr_idx  = idx_q[IDX_W-1:0];
  assign wr_data = mem_rsp_data;
  assign busy    = (state_q != FS_IDLE);
endmodule

// File: rtl/pxu_table.sv
module pxu_table #(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int MAX_PAGES = 512,
  parameter int IDX_W     = 9,
  parameter int ENT_SH    = 3,
  parameter int TW_AW     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [AW-1:0]    fill_data,
  input  logic             tw_we,
  input  logic [TW_AW-1:0] tw_addr,
  input  logic [AW-1:0]    tw_data,
  input  logic             en,
  input  logic             lk_valid,
  input  logic [AW-1:0]    lk_addr,
  output logic             res_valid,
  output logic             res_hit,
  output logic [AW-1:0]    res_paddr,
  output logic             err
);
  localparam int VPN_W = AW - PAGE_BITS;
  localparam int TWI_W = TW_AW - ENT_SH;
  localparam logic [VPN_W-1:0] VPN_LIM = VPN_W'(MAX_PAGES);
  localparam logic [TWI_W-1:0] TWI_LIM = TWI_W'(MAX_PAGES);

  logic [AW-1:0]        frame_q [MAX_PAGES];
  logic [MAX_PAGES-1:0] map_q;

  logic             tw_frame, tw_in;
  logic [TWI_W-1:0] tw_slot;
  logic [IDX_W-1:0] tw_idx;
  assign tw_slot  = tw_addr[TW_AW-1:ENT_SH];
  assign tw_frame = tw_we && (tw_addr[ENT_SH-1:0] == '0);
  assign tw_in    = tw_slot < TWI_LIM;
  assign tw_idx   = tw_slot[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (fill_we) frame_q[fill_idx] <= fill_data;
    if (tw_frame && tw_in) frame_q[tw_idx] <= tw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      err   <= 1'b0;
    end else begin
      if (clr) begin
        map_q <= '0;
      end else begin
        if (fill_we) map_q[fill_idx] <= 1'b1;
        if (tw_frame && tw_in) map_q[tw_idx] <= 1'b1;
      end
      if (tw_frame && !tw_in) err <= 1'b1;
    end
  end

  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] lk_idx;
  logic             hit_c;
  assign vpn    = lk_addr[AW-1:PAGE_BITS];
  assign lk_idx = vpn[IDX_W-1:0];
  assign hit_c  = en && (vpn < VPN_LIM) && map_q[lk_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_paddr <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && hit_c;
      res_paddr <= (lk_valid && hit_c)
                 ? {frame_q[lk_idx][AW-1:PAGE_BITS], lk_addr[PAGE_BITS-1:0]} : '0;
    end
  end
endmodule

// File: rtl/pxu_top.sv
module pxu_top
  import pxu_pkg::*;
#(
  parameter int AW          = PXU_AW,
  parameter int PAGE_BITS   = PXU_PAGE_BITS,
  parameter int MAX_PAGES   = PXU_MAX_PAGES,
  parameter int ENTRY_BYTES = PXU_ENTRY_BYTES,
  parameter int TW_AW       = PXU_TW_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             tw_we,
  input  logic [TW_AW-1:0] tw_addr,
  input  logic [AW-1:0]    tw_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [AW-1:0]    mem_rsp_data,
  input  logic             lk_valid,
  input  logic [AW-1:0]    lk_addr,
  output logic             res_valid,
  output logic             res_hit,
  output logic [AW-1:0]    res_paddr,
  output logic             busy,
  output logic             err
);
  localparam int IDX_W  = $clog2(MAX_PAGES);
  localparam int CNT_W  = IDX_W + 1;
  localparam int ENT_SH = $clog2(ENTRY_BYTES);
  localparam logic [AW-1:0] TBL_BYTES = AW'(MAX_PAGES * ENTRY_BYTES);
  localparam logic [AW-1:0] BASE_MASK = {1'b0, {(AW-1){1'b1}}};

  logic [AW-1:0] base_q, limit_q, base_nx, limit_nx;
  logic [CNT_W-1:0] cnt_nx;

  assign base_nx  = (cfg_we && !cfg_sel) ? cfg_wdata : base_q;
  assign limit_nx = (cfg_we &&  cfg_sel) ? cfg_wdata : limit_q;
  assign cnt_nx   = (limit_nx >= TBL_BYTES) ? CNT_W'(MAX_PAGES)
                                            : limit_nx[CNT_W+ENT_SH-1:ENT_SH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else begin
      base_q  <= base_nx;
      limit_q <= limit_nx;
    end
  end

  logic             f_we;
  logic [IDX_W-1:0] f_idx;
  logic [AW-1:0]    f_data;

  pxu_fill #(.AW(AW), .IDX_W(IDX_W), .CNT_W(CNT_W), .ENT_SH(ENT_SH)) u_fill (
    .clk(clk), .rst_n(rst_n),
    .start(cfg_we), .start_base(base_nx & BASE_MASK), .start_cnt(cnt_nx),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .wr_en(f_we), .wr_idx(f_idx), .wr_data(f_data), .busy(busy)
  );

  pxu_table #(.AW(AW), .PAGE_BITS(PAGE_BITS), .MAX_PAGES(MAX_PAGES),
              .IDX_W(IDX_W), .ENT_SH(ENT_SH), .TW_AW(TW_AW)) u_table (
    .clk(clk), .rst_n(rst_n), .clr(cfg_we),
    .fill_we(f_we), .fill_idx(f_idx), .fill_data(f_data),
    .tw_we(tw_we), .tw_addr(tw_addr), .tw_data(tw_data),
    .en((limit_q != '0) && !busy),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_paddr(res_paddr), .err(err)
  );
endmodule

// File: rtl/pxu_top_chk.sv
module pxu_top_chk #(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int MAX_PAGES = 512
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          lk_valid,
  input logic [AW-1:0] lk_addr,
  input logic          res_valid,
  input logic          res_hit,
  input logic [AW-1:0] res_paddr,
  input logic          busy,
  input logic          err
);
  localparam logic [AW-PAGE_BITS-1:0] VPN_LIM = (AW-PAGE_BITS)'(MAX_PAGES);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9
  AST_BUSY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && busy |=> res_valid && !res_hit); // R10
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid); // R10
  AST_RES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid); // R2
  AST_RES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid); // R2
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> !res_hit || (res_paddr[PAGE_BITS-1:0] == $past(lk_addr[PAGE_BITS-1:0]))); // R2
  AST_HIGH_PAGE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && (lk_addr[AW-1:PAGE_BITS] >= VPN_LIM) |=> !res_hit); // R11
endmodule

bind pxu_top pxu_top_chk #(.AW(AW), .PAGE_BITS(PAGE_BITS), .MAX_PAGES(MAX_PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .res_valid(res_valid), .res_hit(res_hit), .res_paddr(res_paddr), .busy(busy), .err(err)
);

// File: tb/pxu_top_bench.sv
`timescale 1ns/1ps
module pxu_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_we = 0, cfg_sel = 0, tw_we = 0, lk_valid = 0;
  logic [31:0] cfg_wdata = 0, tw_data = 0, lk_addr = 0;
  logic [15:0] tw_addr = 0;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic        res_valid, res_hit, busy, err;
  logic [31:0] res_paddr;

  pxu_top u_pxu_top (.*);

  int n_chk = 0, n_bad = 0;
  int hs_cnt = 0;
  logic [31:0] last_addr = 0;
  logic [2:0] rdy_cnt = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[22:3] + 20'h3C000, 12'h7E5};
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] bm, input int pg, input logic [11:0] off);
    logic [31:0] f;
    f = mem_word(bm + 32'(pg) * 8);
    return {f[31:12], off};
  endfunction

  // memory model: stalls one cycle in four, answers one cycle after acceptance
  always @(posedge clk) begin
    rdy_cnt       <= rdy_cnt + 1'b1;
    mem_req_ready <= (rdy_cnt[1:0] != 2'b11);
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem_word(mem_req_addr);
    if (mem_req_valid && mem_req_ready) begin
      hs_cnt    <= hs_cnt + 1;
      last_addr <= mem_req_addr;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic tbl_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); tw_we = 1; tw_addr = a; tw_data = d;
    @(negedge clk); tw_we = 0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic eh, input logic [31:0] epa, input string tag);
    @(negedge clk); lk_valid = 1; lk_addr = a;
    @(negedge clk); lk_valid = 0;
    chk(res_valid === 1'b1, {tag, " res_valid"}, {31'b0, res_valid}, 32'd1);
    chk(res_hit === eh, {tag, " res_hit"}, {31'b0, res_hit}, {31'b0, eh});
    chk(res_paddr === (eh ? epa : 32'h0), {tag, " res_paddr"}, res_paddr, eh ? epa : 32'h0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
    chk(busy === 1'b0, "R10 fill ends", {31'b0, busy}, 32'd0);
  endtask

  task automatic t_reset();
    chk(busy === 0, "R1 busy", {31'b0, busy}, 0);
    chk(err === 0, "R1 err", {31'b0, err}, 0);
    chk(mem_req_valid === 0, "R1 req", {31'b0, mem_req_valid}, 0);
    chk(res_valid === 0, "R1 res_valid", {31'b0, res_valid}, 0);
    lookup(32'h0000_0123, 0, 0, "R1 lookup");
  endtask

  task automatic t_zero_limit();
    int c0;
    c0 = hs_cnt;
    cfg_write(0, 32'h8002_0000);
    repeat (4) @(negedge clk);
    chk(hs_cnt == c0, "R5 no reads", 32'(hs_cnt), 32'(c0));
    chk(busy === 0, "R5 idle", {31'b0, busy}, 0);
    tbl_write(16'h0000, 32'h1234_5000);
    lookup(32'h0000_0010, 0, 0, "R5 direct write gated");
  endtask

  task automatic t_small();
    int c0;
    c0 = hs_cnt;
    cfg_write(1, 32'd64);
    wait_idle();
    chk(hs_cnt - c0 == 8, "R4 slot count", 32'(hs_cnt - c0), 32'd8);
    chk(last_addr === 32'h0002_0038, "R3 masked address", last_addr, 32'h0002_0038);
    lookup(32'h0000_3123, 1, exp_pa(32'h0002_0000, 3, 12'h123), "R2 page3");
    lookup(32'h0000_7FFF, 1, exp_pa(32'h0002_0000, 7, 12'hFFF), "R2 page7");
    lookup(32'h0000_8000, 0, 0, "R4 page8");
  endtask

  task automatic t_direct();
    tbl_write(16'h0028, 32'hCAFE_B123);
    lookup(32'h0000_5045, 1, 32'hCAFE_B045, "R7 page5");
    tbl_write(16'h002C, 32'h1111_1000);
    lookup(32'h0000_5046, 1, 32'hCAFE_B046, "R8 odd offset");
    tbl_write(16'h0061, 32'h2222_2000);
    lookup(32'h0000_C000, 0, 0, "R8 unaligned no map");
    tbl_write(16'h0060, 32'h3333_3000);
    lookup(32'h0000_C777, 1, 32'h3333_3777, "R7 page12 mapped");
    chk(err === 0, "R9 err low", {31'b0, err}, 0);
    tbl_write(16'h1000, 32'h4444_4000);
    chk(err === 1, "R9 err set", {31'b0, err}, 1);
    lookup(32'h0020_0000, 0, 0, "R11 page512");
    tbl_write(16'h0008, 32'h5555_5000);
    chk(err === 1, "R9 err sticky", {31'b0, err}, 1);
  endtask

  task automatic t_reload();
    cfg_write(0, 32'h0002_0000);
    wait_idle();
    lookup(32'h0000_C000, 0, 0, "R6 page12 cleared");
    lookup(32'h0000_5000, 1, exp_pa(32'h0002_0000, 5, 12'h000), "R6 page5 reloaded");
    cfg_write(1, 32'd12);
    wait_idle();
    lookup(32'h0000_0ABC, 1, exp_pa(32'h0002_0000, 0, 12'hABC), "R4 limit12 page0");
    lookup(32'h0000_1000, 0, 0, "R4 limit12 page1");
  endtask

  task automatic t_full();
    cfg_write(1, 32'h0001_0000);
    repeat (4) @(negedge clk);
    chk(busy === 1, "R10 busy", {31'b0, busy}, 1);
    lookup(32'h0000_0000, 0, 0, "R10 lookup during fill");
    cfg_write(1, 32'h0000_2000);
    wait_idle();
    lookup(32'h001F_F321, 1, exp_pa(32'h0002_0000, 511, 12'h321), "R6 restart page511");
    lookup(32'h0000_1001, 1, exp_pa(32'h0002_0000, 1, 12'h001), "R4 capped page1");
    lookup(32'hFFFF_F000, 0, 0, "R11 top page");
    cfg_write(1, 32'h0);
    lookup(32'h0000_1000, 0, 0, "R5 limit cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_zero_limit();
    t_small();
    t_direct();
    t_reload();
    t_full();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule